// File: doc/BRIEF.md
# DMA Repeat-Mode Address Generator

This block generates the source and destination byte addresses for a single DMA channel. It is intended for cyclic buffers. While the channel enable is low, it captures a starting source address, a starting destination address, a block length N, a cycle count and three mode bits. When the channel is enabled, it presents one transfer request per byte. The current addresses are driven combinationally alongside the request. Each acknowledged byte moves the addresses on.

The block has two modes:

- **Repeat mode.** One side is the repeat area, chosen by a select bit. Its address walks through an N-byte window and then jumps back to its starting value. The other side either stays fixed or increments, under its own mode bit.
- **Normal mode.** The selected side keeps incrementing and never reloads.

A counter tracks how many N-byte cycles remain. At the end of the final cycle the block emits a single-cycle completion pulse and stops requesting. A block length of zero is flagged as a configuration error.

Top module: `dma_rpt_addr_gen`

## Requirements
- R1: While `en` is low, every configuration input is captured on each clock. While `en` is low, `xfer_req`, `done` and `cfg_err` are 0. On the first clock edge that sees `en` high with a non-zero block length, the block goes active, and `xfer_req` is 1 from the following cycle.
- R2: `cfg_rpt_dst` selects the repeat area: 1 selects the destination and 0 selects the source. Each acknowledged byte (`xfer_req` and `xfer_ack` both 1 at a clock edge) increases the repeat-area address by 1.
- R3: In repeat mode (`cfg_rpt_mode` = 1), the acknowledgement of the N-th byte of a cycle reloads the repeat-area address with its captured starting value.
- R4: The side that is not the repeat area follows `cfg_other_inc`. A value of 0 holds that address at its starting value. A value of 1 adds 1 per acknowledged byte, so each cycle ends at the cycle's start plus N.
- R5: A cycle with `xfer_req` high and `xfer_ack` low leaves both addresses unchanged. All address arithmetic wraps modulo 2^ADDR_W.
- R6: The number of N-byte cycles equals the loaded count, and a loaded count of 0 or 1 gives a single cycle. After the last byte of the last cycle is acknowledged, `done` is 1 for exactly one cycle. `xfer_req` then stays 0 until `en` goes low.
- R7: A block length of 0 sets `cfg_err` from the cycle after the enabled edge. `cfg_err` stays set and no request is made until `en` goes low.
- R8: In normal mode (`cfg_rpt_mode` = 0), the side chosen by `cfg_rpt_dst` increments on every byte and never reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; low = configuration capture |
| cfg_src | input | ADDR_W | Starting source address |
| cfg_dst | input | ADDR_W | Starting destination address |
| cfg_blk | input | BLK_W | Block length N in bytes |
| cfg_cnt | input | CNT_W | Number of N-byte cycles |
| cfg_rpt_dst | input | 1 | 1: destination is repeat area; 0: source |
| cfg_other_inc | input | 1 | Non-repeat side: 0 fixed, 1 increment |
| cfg_rpt_mode | input | 1 | 1: repeat mode; 0: normal mode |
| xfer_req | output | 1 | Byte transfer request |
| xfer_ack | input | 1 | Byte transfer acknowledge |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Zero block length error |

## Verification
The bench builds the block with BLK_W = 4 and CNT_W = 3, keeping ADDR_W at 32. These widths keep windows short enough to sweep every combination of the three mode bits, together with block lengths 1 to 5 and counts 0 to 3. That sweep reaches every wrap point, the count-of-zero and count-of-one edge cases, and single-byte windows. One run starts the source near the top of the 32-bit space, so that address rollover falls inside a window. Idle gaps in the acknowledge stream check that the addresses hold while no byte is acknowledged.

// File: rtl/dma_rpt_pkg.sv
package dma_rpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_FIN    = 2'd2
  } seq_state_e;

  localparam int SIDE_SRC = 0;
  localparam int SIDE_DST = 1;
  localparam int N_SIDES  = 2;
endpackage

// File: rtl/dma_rpt_side.sv
module dma_rpt_side #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] init,
  input  logic              step,
  input  logic              blk_end,
  input  logic              is_rpt,
  input  logic              wrap_en,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base
);
  // Next address for one acknowledged byte.
  function automatic logic [ADDR_W-1:0] next_addr(
    input logic [ADDR_W-1:0] cur,
    input logic [ADDR_W-1:0] start,
    input logic              rpt,
    input logic              wrap,
    input logic              last,
    input logic              incr
  );
    if (rpt)
      return (wrap && last) ? start : cur + {{(ADDR_W-1){1'b0}}, 1'b1};
    else if (incr)
      return cur + {{(ADDR_W-1){1'b0}}, 1'b1};
    else
      return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      base <= '0;
    end else if (load) begin
      addr <= init;
      base <= init;
    end else if (step) begin
      addr <= next_addr(addr, base, is_rpt, wrap_en, blk_end, inc);
    end
  end
endmodule

// File: rtl/dma_rpt_seq.sv
module dma_rpt_seq
  import dma_rpt_pkg::*;
#(
  parameter int BLK_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [BLK_W-1:0] cfg_blk,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic             xfer_ack,
  output logic             xfer_req,
  output logic             step,
  output logic             blk_end,
  output logic             done,
  output logic             cfg_err
);
  localparam logic [BLK_W-1:0] BLK_ONE = {{(BLK_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  seq_state_e       state;
  logic [BLK_W-1:0] blk_r;
  logic [BLK_W-1:0] byte_cnt;
  logic [CNT_W-1:0] rcnt;
  logic             last_cycle;

  assign xfer_req   = (state == ST_ACTIVE);
  assign step       = xfer_req && xfer_ack;
  assign blk_end    = step && (byte_cnt == blk_r - BLK_ONE);
  assign last_cycle = (rcnt <= CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      blk_r    <= '0;
      byte_cnt <= '0;
      rcnt     <= '0;
      done     <= 1'b0;
      cfg_err  <= 1'b0;
    end else if (!en) begin
      state    <= ST_IDLE;
      blk_r    <= cfg_blk;
      rcnt     <= cfg_cnt;
      byte_cnt <= '0;
      done     <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (blk_r == '0) cfg_err <= 1'b1;
          else             state   <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (blk_end) begin
            byte_cnt <= '0;
            if (last_cycle) begin
              done  <= 1'b1;
              state <= ST_FIN;
            end else begin
              rcnt <= rcnt - CNT_ONE;
            end
          end else if (step) begin
            byte_cnt <= byte_cnt + BLK_ONE;
          end
        end
        default: state <= ST_FIN;
      endcase
    end
  end
endmodule

// File: rtl/dma_rpt_addr_gen.sv
module dma_rpt_addr_gen
  import dma_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [BLK_W-1:0]  cfg_blk,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              cfg_rpt_dst,
  input  logic              cfg_other_inc,
  input  logic              cfg_rpt_mode,
  output logic              xfer_req,
  input  logic              xfer_ack,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              done,
  output logic              cfg_err
);
  // Named internal events, visible to the bound checker.
  logic              step;
  logic              blk_end;
  logic              rpt_dst_q;
  logic              other_inc_q;
  logic              rpt_mode_q;
  logic [ADDR_W-1:0] src_base;
  logic [ADDR_W-1:0] dst_base;

  logic [ADDR_W-1:0] side_init [N_SIDES];
  logic [ADDR_W-1:0] side_addr [N_SIDES];
  logic [ADDR_W-1:0] side_base [N_SIDES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_dst_q   <= 1'b0;
      other_inc_q <= 1'b0;
      rpt_mode_q  <= 1'b0;
    end else if (!en) begin
      rpt_dst_q   <= cfg_rpt_dst;
      other_inc_q <= cfg_other_inc;
      rpt_mode_q  <= cfg_rpt_mode;
    end
  end

  dma_rpt_seq #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cfg_blk  (cfg_blk),
    .cfg_cnt  (cfg_cnt),
    .xfer_ack (xfer_ack),
    .xfer_req (xfer_req),
    .step     (step),
    .blk_end  (blk_end),
    .done     (done),
    .cfg_err  (cfg_err)
  );

  assign side_init[SIDE_SRC] = cfg_src;
  assign side_init[SIDE_DST] = cfg_dst;

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    logic is_rpt;
    assign is_rpt = (g == SIDE_DST) ? rpt_dst_q : !rpt_dst_q;
    dma_rpt_side #(.ADDR_W(ADDR_W)) u_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (!en),
      .init    (side_init[g]),
      .step    (step),
      .blk_end (blk_end),
      .is_rpt  (is_rpt),
      .wrap_en (rpt_mode_q),
      .inc     (other_inc_q),
      .addr    (side_addr[g]),
      .base    (side_base[g])
    );
  end

  assign src_addr = side_addr[SIDE_SRC];
  assign dst_addr = side_addr[SIDE_DST];
  assign src_base = side_base[SIDE_SRC];
  assign dst_base = side_base[SIDE_DST];
endmodule

// File: rtl/dma_rpt_addr_gen_chk.sv
module dma_rpt_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              xfer_req,
  input logic              xfer_ack,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              done,
  input logic              cfg_err,
  input logic              step,
  input logic              blk_end,
  input logic              rpt_dst_q,
  input logic              other_inc_q,
  input logic              rpt_mode_q,
  input logic [ADDR_W-1:0] src_base,
  input logic [ADDR_W-1:0] dst_base
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!xfer_req && !done && !cfg_err));

  p_rpt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !blk_end && rpt_dst_q) |=> (dst_addr == $past(dst_addr) + ONE));

  p_dst_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && rpt_mode_q && rpt_dst_q) |=> (dst_addr == dst_base));

  p_src_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && rpt_mode_q && !rpt_dst_q) |=> (src_addr == src_base));

  p_fixed_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !other_inc_q && rpt_dst_q) |=> $stable(src_addr));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(xfer_req && xfer_ack)) |=> ($stable(src_addr) && $stable(dst_addr)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !xfer_req));

  p_err_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !xfer_req);
endmodule

bind dma_rpt_addr_gen dma_rpt_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_rpt_addr_gen_test.sv
`timescale 1ns/1ps
module dma_rpt_addr_gen_test;
  localparam int AW = 32;
  localparam int BW = 4;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [AW-1:0] cfg_src = '0;
  logic [AW-1:0] cfg_dst = '0;
  logic [BW-1:0] cfg_blk = '0;
  logic [CW-1:0] cfg_cnt = '0;
  logic          cfg_rpt_dst = 1'b0;
  logic          cfg_other_inc = 1'b0;
  logic          cfg_rpt_mode = 1'b0;
  logic          xfer_ack = 1'b0;
  logic          xfer_req;
  logic [AW-1:0] src_addr;
  logic [AW-1:0] dst_addr;
  logic          done;
  logic          cfg_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_rpt_addr_gen #(.ADDR_W(AW), .BLK_W(BW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_blk(cfg_blk), .cfg_cnt(cfg_cnt),
    .cfg_rpt_dst(cfg_rpt_dst), .cfg_other_inc(cfg_other_inc), .cfg_rpt_mode(cfg_rpt_mode),
    .xfer_req(xfer_req), .xfer_ack(xfer_ack),
    .src_addr(src_addr), .dst_addr(dst_addr), .done(done), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_addr(input string req, input logic [AW-1:0] es,
                          input logic [AW-1:0] ed);
    chk(src_addr == es, req, src_addr, es);
    chk(dst_addr == ed, req, dst_addr, ed);
  endtask

  // One complete programmed run, with expected addresses computed arithmetically.
  task automatic run(input bit rd, input bit oi, input bit md, input int blk,
                     input int cnt, input logic [AW-1:0] s0, input logic [AW-1:0] d0);
    int cycles;
    int n;
    logic [AW-1:0] r0, o0, er, eo, es, ed;
    @(negedge clk);
    en = 1'b0; xfer_ack = 1'b0;
    cfg_src = s0; cfg_dst = d0; cfg_blk = BW'(blk); cfg_cnt = CW'(cnt);
    cfg_rpt_dst = rd; cfg_other_inc = oi; cfg_rpt_mode = md;
    @(negedge clk);
    chk(!xfer_req && !done && !cfg_err, "R1 idle", {29'd0, xfer_req, done, cfg_err}, '0);
    chk_addr("R1 load", s0, d0);
    en = 1'b1;
    @(negedge clk);
    chk(xfer_req, "R1 first request", {31'd0, xfer_req}, 1);
    cycles = (cnt <= 1) ? 1 : cnt;
    r0 = rd ? d0 : s0;
    o0 = rd ? s0 : d0;
    n = 0;
    for (int c = 0; c < cycles; c++) begin
      for (int k = 0; k < blk; k++) begin
        er = md ? r0 + AW'(k) : r0 + AW'(n);
        eo = oi ? o0 + AW'(n) : o0;
        es = rd ? eo : er;
        ed = rd ? er : eo;
        chk(xfer_req, "R6 request held", {31'd0, xfer_req}, 1);
        chk_addr(md ? (rd ? "R2 R3 R4 dst window" : "R2 R3 R4 src window")
                    : "R8 R4 normal", es, ed);
        if ((n % 3) == 2) begin
          xfer_ack = 1'b0;
          @(negedge clk);
          chk_addr("R5 hold without ack", es, ed);
        end
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        n++;
      end
    end
    chk(done && !xfer_req, "R6 done pulse", {30'd0, done, xfer_req}, 2);
    er = md ? r0 : r0 + AW'(n);
    eo = oi ? o0 + AW'(n) : o0;
    chk_addr("R3 R4 R8 final", rd ? eo : er, rd ? er : eo);
    @(negedge clk);
    chk(!done && !xfer_req, "R6 after done", {30'd0, done, xfer_req}, 0);
    en = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!xfer_req && !done && !cfg_err, "R1 reset", {29'd0, xfer_req, done, cfg_err}, 0);
    chk_addr("R1 reset addr", '0, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int rd = 0; rd < 2; rd++)
      for (int oi = 0; oi < 2; oi++)
        for (int md = 0; md < 2; md++)
          for (int blk = 1; blk <= 5; blk++)
            for (int cnt = 0; cnt <= 3; cnt++)
              run(rd[0], oi[0], md[0], blk, cnt,
                  32'h1000_0000 + AW'(blk * 64), 32'h2000_0100 + AW'(cnt * 16));

    // Address rollover inside a window (R5).
    run(1'b0, 1'b1, 1'b1, 5, 3, 32'hFFFF_FFFE, 32'hFFFF_FFFC);
    run(1'b1, 1'b1, 1'b0, 4, 2, 32'hFFFF_FFFD, 32'h0000_0010);

    // Zero block length (R7).
    @(negedge clk);
    en = 1'b0; cfg_blk = '0; cfg_cnt = 3'd2;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk(cfg_err && !xfer_req, "R7 error set", {30'd0, cfg_err, xfer_req}, 2);
    xfer_ack = 1'b1;
    repeat (4) @(negedge clk);
    chk(cfg_err && !xfer_req, "R7 error held", {30'd0, cfg_err, xfer_req}, 2);
    xfer_ack = 1'b0;
    en = 1'b0;
    @(negedge clk);
    chk(!cfg_err, "R7 error cleared", {31'd0, cfg_err}, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule